// File: doc/BRIEF.md
# Fieldbus Transmit Frame Sequencer

This block turns bytes written into a small transmit queue into a complete half-duplex fieldbus frame on a Manchester-coded line. A frame opens with a configurable run of preamble bytes and a start delimiter. It then carries the queued bytes in write order, and it closes with a stop delimiter. No length field exists: the frame ends when the queue runs dry. Every half-bit is one line symbol, held for a parameterised number of clock cycles, and the symbols follow one another without gaps.

A frame is launched only while the receive path reports idle and the jabber inhibitor's enable is high, so the shared medium is never driven during reception. When the enable falls in the middle of a frame, the line is released at once. An output-polarity option inverts the coded symbols. The block also reports the queue level, a full flag and a level-threshold alarm that raises an interrupt unless it is masked.

Top module: `fbt_tx_sequencer`

## Requirements
- R1: After a synchronous reset, line_en and line_out are 0, fifo_level is 0, and fifo_full, thresh_alarm and irq are 0.
- R2: A write is stored while fewer than 16 bytes are queued and is dropped when 16 are queued. fifo_full is 1 exactly when the level is 16.
- R3: A frame starts only when the queue is non-empty, rx_busy is 0 and tx_enable is 1. While rx_busy or !tx_enable holds, line_en stays 0.
- R4: A frame begins with N preamble bytes of 0x55, where N is pre_count (3 bits). A pre_count of 0 sends one preamble byte.
- R5: The start delimiter follows the preamble as 16 half-bit symbols 10 11 00 10 01 00 11 01 (1 = line high, first symbol leftmost).
- R6: Queued bytes follow the start delimiter in write order. Each byte goes MSB first, with bit 1 as symbols 10 and bit 0 as symbols 01. Every symbol lasts SYM_DIV cycles and there is no gap between elements.
- R7: When the queue is empty at a byte boundary, the stop delimiter 10 11 00 11 00 10 01 10 is sent and line_en then falls.
- R8: With invert_pol at 1, every symbol of the frame is inverted. line_out is 0 whenever line_en is 0.
- R9: thresh_alarm is 1 when thresh is in 1..15 and fifo_level >= thresh, and it is 0 when thresh is 0. irq equals thresh_alarm when thresh_mask is 0 and is 0 otherwise.
- R10: When tx_enable falls during a frame, line_en is 0 from the next clock edge. Bytes not yet taken stay queued, and the next frame starts again from the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| rx_busy | input | 1 | Receive path active; holds off a new frame |
| tx_enable | input | 1 | Jabber inhibitor enable; low blocks or aborts a frame |
| invert_pol | input | 1 | Invert coded line symbols |
| pre_count | input | 3 | Number of preamble bytes (0 means 1) |
| thresh | input | 4 | Level threshold for the alarm (1..15, 0 disables) |
| thresh_mask | input | 1 | Masks the threshold alarm from irq when 1 |
| fifo_level | output | 5 | Bytes currently queued |
| fifo_full | output | 1 | Queue holds 16 bytes |
| thresh_alarm | output | 1 | Level at or above threshold |
| irq | output | 1 | Unmasked threshold alarm |
| line_en | output | 1 | Line is being driven |
| line_out | output | 1 | Current half-bit symbol |

## Verification
The cycle-level rules are checked on every clock: no new frame while reception is active, the immediate line release on a dropped enable, a nonzero preamble count inside the preamble phase, the queue level saturating at full and never dropping below empty, a quiet line while undriven, and symbols held steady between shift points. The bit-exact frame content cannot be seen by any single-cycle property. This covers the preamble count including the zero case, both delimiter patterns, byte order and MSB-first coding, inversion, and where the stop delimiter falls. The bench's captured-frame comparisons show it, together with the dropped writes beyond 16 and the retention of queued bytes across an abort.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    localparam int SYM_PER_WORD = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PRE,
        SEQ_SFD,
        SEQ_DATA
    } seq_state_e;

    typedef struct packed {
        logic                    valid;
        logic [SYM_PER_WORD-1:0] sym;
    } sym_word_t;

    localparam logic [7:0]              PREAMBLE_BYTE = 8'h55;
    // 1 N+ N- 1 0 N- N+ 0 as half-bit symbols
    localparam logic [SYM_PER_WORD-1:0] START_SYMS    = 16'hB24D;
    // 1 N+ N- N+ N- 1 0 1 as half-bit symbols
    localparam logic [SYM_PER_WORD-1:0] END_SYMS      = 16'hB326;

    // Expand a byte into 16 half-bit symbols, MSB first: 1 -> 10, 0 -> 01
    function automatic logic [SYM_PER_WORD-1:0] manchester(input logic [7:0] b);
        logic [SYM_PER_WORD-1:0] w;
        for (int i = 0; i < 8; i++) begin
            w[2*i+1] = b[i];
            w[2*i]   = ~b[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/fbt_fifo.sv
module fbt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [W-1:0]    din,
    input  logic            pop,
    output logic [W-1:0]    dout,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVLW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= nxt(wp);
            if (pop_ok)  rp <= nxt(rp);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full && !pop |=> level == LVLW'(DEPTH)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        empty && !push |=> empty); // R2

endmodule

// File: rtl/fbt_serializer.sv
module fbt_serializer
    import fbt_pkg::*;
#(
    parameter int SYM_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      abort,
    input  sym_word_t word,
    output logic      need,
    output logic      busy,
    output logic      sym_bit
);
    localparam int DIVW = (SYM_DIV > 1) ? $clog2(SYM_DIV) : 1;
    localparam int SCW  = $clog2(SYM_PER_WORD);

    logic [SYM_PER_WORD-1:0] sh;
    logic [SCW-1:0]          symcnt;
    logic [DIVW-1:0]         div;
    logic                    div_end, last, load;

    assign div_end = (div == DIVW'(SYM_DIV - 1));
    assign last    = busy && div_end && (symcnt == SCW'(SYM_PER_WORD - 1));
    assign need    = !busy || last;
    assign load    = need && word.valid && !abort;
    assign sym_bit = sh[SYM_PER_WORD-1];

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy   <= 1'b0;
            sh     <= '0;
            symcnt <= '0;
            div    <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            sh     <= word.sym;
            symcnt <= '0;
            div    <= '0;
        end else if (last) begin
            busy   <= 1'b0;
            sh     <= '0;
        end else if (busy) begin
            if (div_end) begin
                div    <= '0;
                sh     <= sh << 1;
                symcnt <= symcnt + 1'b1;
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    AST_LOAD_DRIVES: assert property (@(posedge clk) disable iff (rst)
        load |=> busy); // R6
    AST_SYM_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy && !div_end && !abort |=> $stable(sym_bit)); // R6

endmodule

// File: rtl/fbt_sequencer.sv
module fbt_sequencer
    import fbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_head,
    input  logic       rx_busy,
    input  logic       tx_enable,
    input  logic [2:0] pre_count,
    input  logic       ser_need,
    output sym_word_t  word,
    output logic       pop
);
    seq_state_e state;
    logic [2:0] pre_left;
    logic [2:0] n_pre;
    logic       accept;

    assign n_pre  = (pre_count == 3'd0) ? 3'd1 : pre_count;
    assign accept = ser_need && word.valid;
    assign pop    = accept && (state == SEQ_DATA) && !fifo_empty;

    always_comb begin
        word.valid = 1'b0;
        word.sym   = manchester(PREAMBLE_BYTE);
        case (state)
            SEQ_IDLE: word.valid = !fifo_empty && !rx_busy && tx_enable;
            SEQ_PRE:  word.valid = tx_enable;
            SEQ_SFD: begin
                word.valid = tx_enable;
                word.sym   = START_SYMS;
            end
            SEQ_DATA: begin
                word.valid = tx_enable;
                word.sym   = fifo_empty ? END_SYMS : manchester(fifo_head);
            end
            default: word.valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_enable) begin
            state    <= SEQ_IDLE;
            pre_left <= '0;
        end else if (accept) begin
            case (state)
                SEQ_IDLE: begin
                    state    <= (n_pre == 3'd1) ? SEQ_SFD : SEQ_PRE;
                    pre_left <= n_pre - 3'd1;
                end
                SEQ_PRE: begin
                    pre_left <= pre_left - 3'd1;
                    if (pre_left == 3'd1) state <= SEQ_SFD;
                end
                SEQ_SFD:  state <= SEQ_DATA;
                SEQ_DATA: if (fifo_empty) state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        state == SEQ_IDLE && rx_busy |=> state == SEQ_IDLE); // R3
    AST_PRE_LEFT: assert property (@(posedge clk) disable iff (rst)
        state == SEQ_PRE |-> pre_left != 3'd0); // R4
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> state == SEQ_IDLE); // R10

endmodule

// File: rtl/fbt_tx_sequencer.sv
module fbt_tx_sequencer
    import fbt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int SYM_DIV = 4,
    parameter int LVLW    = $clog2(DEPTH + 1),
    parameter int THW     = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_valid,
    input  logic [7:0]      wr_data,
    input  logic            rx_busy,
    input  logic            tx_enable,
    input  logic            invert_pol,
    input  logic [2:0]      pre_count,
    input  logic [THW-1:0]  thresh,
    input  logic            thresh_mask,
    output logic [LVLW-1:0] fifo_level,
    output logic            fifo_full,
    output logic            thresh_alarm,
    output logic            irq,
    output logic            line_en,
    output logic            line_out
);
    logic       fifo_empty, pop, ser_need, ser_bit;
    logic [7:0] fifo_head;
    sym_word_t  word;

    fbt_fifo #(.DEPTH(DEPTH), .W(8), .LVLW(LVLW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_valid),
        .din   (wr_data),
        .pop   (pop),
        .dout  (fifo_head),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    fbt_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .rx_busy    (rx_busy),
        .tx_enable  (tx_enable),
        .pre_count  (pre_count),
        .ser_need   (ser_need),
        .word       (word),
        .pop        (pop)
    );

    fbt_serializer #(.SYM_DIV(SYM_DIV)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .abort   (!tx_enable),
        .word    (word),
        .need    (ser_need),
        .busy    (line_en),
        .sym_bit (ser_bit)
    );

    assign line_out     = line_en && (ser_bit ^ invert_pol);
    assign thresh_alarm = (thresh != '0) && (fifo_level >= LVLW'(thresh));
    assign irq          = thresh_alarm && !thresh_mask;

    AST_JABBER_CUT: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !line_en); // R10
    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (rst)
        !line_en |-> !line_out); // R8
    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        !line_en && (rx_busy || fifo_empty) |=> !line_en); // R3

endmodule

// File: tb/test_fbt_tx_sequencer.sv
module test_fbt_tx_sequencer;
    localparam int DEPTH   = 16;
    localparam int SYM_DIV = 4;
    localparam int CAPN    = 4096;

    logic       clk = 1'b0;
    logic       rst, wr_valid, rx_busy, tx_enable, invert_pol, thresh_mask;
    logic [7:0] wr_data;
    logic [2:0] pre_count;
    logic [3:0] thresh;
    logic [4:0] fifo_level;
    logic       fifo_full, thresh_alarm, irq, line_en, line_out;

    always #10 clk = ~clk;

    fbt_tx_sequencer #(.DEPTH(DEPTH), .SYM_DIV(SYM_DIV)) i_fbt_tx_sequencer (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .rx_busy(rx_busy), .tx_enable(tx_enable), .invert_pol(invert_pol),
        .pre_count(pre_count), .thresh(thresh), .thresh_mask(thresh_mask),
        .fifo_level(fifo_level), .fifo_full(fifo_full),
        .thresh_alarm(thresh_alarm), .irq(irq),
        .line_en(line_en), .line_out(line_out)
    );

    int errors = 0;
    int checks = 0;
    logic [7:0]  mdl [0:63];
    int          mdl_n = 0;
    logic        cap [0:CAPN-1];
    int          cap_n;
    logic [15:0] wds [0:63];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [7:0] b);
        logic [15:0] w;
        for (int i = 0; i < 8; i++) begin
            w[15-2*i] = b[7-i];
            w[14-2*i] = ~b[7-i];
        end
        return w;
    endfunction

    task automatic write_byte(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
        if (mdl_n < DEPTH) begin
            mdl[mdl_n] = b;
            mdl_n++;
        end
    endtask

    task automatic capture_frame();
        cap_n = 0;
        while (!line_en) @(negedge clk);
        while (line_en && cap_n < CAPN) begin
            cap[cap_n] = line_out;
            cap_n++;
            @(negedge clk);
        end
    endtask

    task automatic verify_frame(input int pre_cfg, input bit pol);
        int npre, nw, len;
        int bad_pre, bad_sfd, bad_dat, bad_efd;
        npre = (pre_cfg == 0) ? 1 : pre_cfg;
        for (int i = 0; i < npre; i++) wds[i] = enc(8'h55);
        wds[npre] = 16'hB24D;
        for (int i = 0; i < mdl_n; i++) wds[npre+1+i] = enc(mdl[i]);
        nw = npre + mdl_n + 2;
        wds[nw-1] = 16'hB326;
        len = nw * 16 * SYM_DIV;
        check(cap_n == len, "R6", "frame length in cycles", cap_n, len);
        bad_pre = 0; bad_sfd = 0; bad_dat = 0; bad_efd = 0;
        for (int j = 0; j < len && j < cap_n; j++) begin
            int s, w;
            logic e;
            s = j / SYM_DIV;
            w = s / 16;
            e = wds[w][15 - (s % 16)] ^ pol;
            if (cap[j] !== e) begin
                if (w < npre)          bad_pre++;
                else if (w == npre)    bad_sfd++;
                else if (w == nw - 1)  bad_efd++;
                else                   bad_dat++;
            end
        end
        check(bad_pre == 0, "R4", "preamble symbol mismatches", bad_pre, 0);
        check(bad_sfd == 0, "R5", "start delimiter mismatches", bad_sfd, 0);
        check(bad_dat == 0, "R6", "payload symbol mismatches", bad_dat, 0);
        check(bad_efd == 0, "R7", "stop delimiter mismatches", bad_efd, 0);
        if (pol)
            check(bad_pre + bad_sfd + bad_dat + bad_efd == 0, "R8",
                  "inverted frame mismatches", bad_pre + bad_sfd + bad_dat + bad_efd, 0);
    endtask

    task automatic send_frame(input int pre_cfg, input bit pol);
        pre_count  = 3'(pre_cfg);
        invert_pol = pol;
        tx_enable  = 1'b1;
        rx_busy    = 1'b0;
        capture_frame();
        rx_busy = 1'b1;
        verify_frame(pre_cfg, pol);
        check(fifo_level == 0, "R7", "queue empty after frame", fifo_level, 0);
        check(line_out == 1'b0, "R8", "idle line low", line_out, 0);
        mdl_n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681357));
        rst = 1'b1; wr_valid = 1'b0; wr_data = '0; rx_busy = 1'b1;
        tx_enable = 1'b1; invert_pol = 1'b0; pre_count = '0;
        thresh = '0; thresh_mask = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(line_en == 0 && line_out == 0, "R1", "line idle after reset", line_en, 0);
        check(fifo_level == 0 && !fifo_full, "R1", "queue empty after reset", fifo_level, 0);
        check(!thresh_alarm && !irq, "R1", "no alarm after reset", irq, 0);

        // R3: receive activity holds the frame off
        write_byte(8'hA5); write_byte(8'h00); write_byte(8'hFF);
        repeat (40) @(negedge clk);
        check(line_en == 0, "R3", "no start while rx_busy", line_en, 0);
        check(fifo_level == 3, "R2", "three bytes queued", fifo_level, 3);
        send_frame(0, 1'b0);    // R4: count 0 gives one preamble byte

        // R3: low enable blocks the start
        write_byte(8'h3C); write_byte(8'h81);
        tx_enable = 1'b0;
        rx_busy   = 1'b0;
        repeat (40) @(negedge clk);
        check(line_en == 0, "R3", "no start while enable low", line_en, 0);
        send_frame(3, 1'b1);    // R8 inverted frame

        // R2: overfill, writes beyond 16 dropped
        rx_busy = 1'b1;
        for (int i = 0; i < 20; i++) write_byte(8'($urandom));
        check(fifo_level == 16, "R2", "level saturates", fifo_level, 16);
        check(fifo_full == 1'b1, "R2", "full flag", fifo_full, 1);
        thresh = 4'd0; thresh_mask = 1'b0;
        check(!thresh_alarm && !irq, "R9", "threshold 0 disables alarm", thresh_alarm, 0);
        send_frame(7, 1'b0);
        check(fifo_full == 1'b0, "R2", "full clears after drain", fifo_full, 0);

        // R10: abort during preamble keeps queued bytes
        for (int i = 0; i < 4; i++) write_byte(8'($urandom));
        pre_count = 3'd2; invert_pol = 1'b0; rx_busy = 1'b0;
        while (!line_en) @(negedge clk);
        repeat (20) @(negedge clk);
        tx_enable = 1'b0;
        @(negedge clk);
        check(line_en == 0, "R10", "line released after enable drop", line_en, 0);
        check(fifo_level == 4, "R10", "queued bytes retained", fifo_level, 4);
        repeat (10) @(negedge clk);
        check(line_en == 0, "R10", "line stays released", line_en, 0);
        send_frame(2, 1'b0);

        // R9: random levels, thresholds and masks
        for (int t = 0; t < 6; t++) begin
            int k;
            rx_busy = 1'b1;
            k = $urandom_range(1, 16);
            for (int i = 0; i < k; i++) write_byte(8'($urandom));
            for (int r = 0; r < 4; r++) begin
                bit ea, ei;
                thresh      = 4'($urandom_range(0, 15));
                thresh_mask = 1'($urandom);
                #1;
                ea = (thresh != 0) && (k >= thresh);
                ei = ea && !thresh_mask;
                check(thresh_alarm == ea, "R9", "threshold alarm", thresh_alarm, ea);
                check(irq == ei, "R9", "masked irq", irq, ei);
            end
            send_frame(int'($urandom_range(0, 7)), 1'($urandom));
        end

        // Random frames
        for (int t = 0; t < 6; t++) begin
            int k;
            rx_busy = 1'b1;
            k = $urandom_range(1, 10);
            for (int i = 0; i < k; i++) write_byte(8'($urandom));
            send_frame(int'($urandom_range(0, 7)), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule